// File: doc/BRIEF.md
# Parallel memory read controller

This block sits on the host side of a slow, asynchronous, byte-wide parallel memory and turns a one-cycle read request into a correctly timed access. The requester presents a 15-bit address with a start pulse. The controller drives the address and an active-low chip select onto the memory pins. It lowers an active-low read strobe at the right point, captures the returned byte and hands it back with a one-cycle done pulse.

All timing is counted in system clock cycles. The memory's address-to-data time, strobe-to-data time and bus release time are given as parameters in nanoseconds, together with the clock period. Each one is turned into a whole cycle count at elaboration. The strobe is delayed after chip select so that both data deadlines expire in the same cycle, and the byte is sampled in that cycle. Because the memory gives no output hold, the enables are released on the same edge that captures the data. After release, a bus-float gap is kept before chip select may fall again. While an access or its gap is in progress, the controller reports busy and ignores further start pulses.

Top module: `pmem_rd_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request, mem_ce_n and mem_oe_n are 1, rd_done and rd_busy are 0, and rd_data is 0.
- R2: A start pulse sampled while rd_busy is 0 is accepted. On the next cycle mem_ce_n is 0 and mem_addr equals the requested address.
- R3: mem_oe_n falls LEAD = SAMPLE - OE_C cycles after mem_ce_n falls, where SAMPLE = max(ACC_C, OE_C). When LEAD is 0, both fall on the same edge.
- R4: The byte is captured on the edge SAMPLE cycles after mem_ce_n fell. rd_data then equals the value on mem_data_in in the last cycle before that edge, and rd_done is 1 in the first cycle after it.
- R5: mem_ce_n and mem_oe_n rise together on the capture edge. mem_oe_n is never 0 while mem_ce_n is 1.
- R6: mem_addr does not change while mem_ce_n stays 0.
- R7: After release, mem_ce_n stays 1 for at least FLOAT_C cycles. With start held high, it stays 1 for exactly FLOAT_C cycles.
- R8: rd_busy is 1 from acceptance until the float gap has run out. A start pulse seen while rd_busy is 1 changes neither mem_addr nor the access in progress, and starts no later access.
- R9: Each delay converts to cycles as ceil(ns / CLK_PERIOD_NS), with a minimum of 1. For example, 150 ns at an 8 ns clock gives 19 cycles, and 0 ns gives 1.
- R10: rd_done is high for exactly one cycle per access. rd_data holds its value until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_start | input | 1 | One-cycle read request |
| rd_addr | input | ADDR_W | Byte address of the request |
| rd_data | output | DATA_W | Captured byte |
| rd_done | output | 1 | One-cycle pulse when rd_data is new |
| rd_busy | output | 1 | Access or float gap in progress; start is ignored |
| mem_addr | output | ADDR_W | Address pins of the memory |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_data_in | input | DATA_W | Data pins of the memory |

## Verification
Some properties are checked on every cycle. The strobe is never low without chip select, and the address holds while chip select is low. The enables are released together with the done pulse, and done lasts one cycle. The low window spans exactly SAMPLE cycles, and the high window before each new access is at least FLOAT_C cycles. A start seen while busy leaves the address untouched.

Other behaviour only the bench scenarios can show. A bench memory model returns a corrupted byte until both of its own deadlines have passed, so a premature capture reads wrong data. The bench also covers the exact strobe lead for two parameter sets, including the same-edge case, and the ceiling and minimum conversions. It further checks the exact gap under a held start and the absence of any phantom access after an ignored request.

// File: rtl/pmem_rd_pkg.sv
`timescale 1ns/1ps
package pmem_rd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACCESS = 2'd1,
      ST_FLOAT  = 2'd2
   } rd_state_e;

   // nanoseconds to whole clock cycles, rounded up, never below one
   function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                             input int unsigned period);
      int unsigned c;
      c = (ns + period - 1) / period;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int unsigned umax(input int unsigned a,
                                        input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pmem_rd_sched.sv
`timescale 1ns/1ps
module pmem_rd_sched
   import pmem_rd_pkg::*;
#(
   parameter int unsigned SAMPLE_CYC = 12,
   parameter int unsigned OE_CYC     = 6,
   parameter int unsigned FLOAT_CYC  = 4,
   parameter int unsigned CNT_W      = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic accept,
   output logic capture,
   output logic ce_n,
   output logic oe_n,
   output logic done,
   output logic busy
);

   localparam int unsigned OE_LEAD = SAMPLE_CYC - OE_CYC;

   if (OE_CYC > SAMPLE_CYC) begin : g_bad_oe
      $error("strobe delay exceeds sample point");
   end
   if ((1 << CNT_W) <= umax(SAMPLE_CYC, FLOAT_CYC)) begin : g_bad_cnt
      $error("counter too narrow");
   end

   rd_state_e        state;
   logic [CNT_W-1:0] cnt;
   logic             ready;
   logic             oe_at_launch;

   // strobe either goes low with chip select or waits for the lead
   if (OE_LEAD == 0) begin : g_oe_same_edge
      assign oe_at_launch = 1'b0;
   end else begin : g_oe_delayed
      assign oe_at_launch = 1'b1;
   end

   assign ready   = (state == ST_IDLE) || ((state == ST_FLOAT) && (cnt == '0));
   assign accept  = start && ready;
   assign capture = (state == ST_ACCESS) && (cnt == '0);
   assign busy    = !ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         ce_n  <= 1'b1;
         oe_n  <= 1'b1;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            state <= ST_ACCESS;
            cnt   <= CNT_W'(SAMPLE_CYC - 1);
            ce_n  <= 1'b0;
            oe_n  <= oe_at_launch;
         end else begin
            case (state)
               ST_ACCESS: begin
                  if (cnt == '0) begin
                     state <= ST_FLOAT;
                     cnt   <= CNT_W'(FLOAT_CYC - 1);
                     ce_n  <= 1'b1;
                     oe_n  <= 1'b1;
                     done  <= 1'b1;
                  end else begin
                     cnt <= cnt - 1'b1;
                     if (cnt == CNT_W'(OE_CYC)) oe_n <= 1'b0;
                  end
               end
               ST_FLOAT: begin
                  if (cnt == '0) state <= ST_IDLE;
                  else           cnt   <= cnt - 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   // window counters used only by the checks below
   logic [CNT_W-1:0] lo_cnt;
   logic [CNT_W-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_cnt <= '0;
         hi_cnt <= CNT_W'(FLOAT_CYC);
      end else begin
         if (!ce_n) lo_cnt <= lo_cnt + 1'b1;
         else       lo_cnt <= '0;
         if (ce_n) begin
            if (hi_cnt < CNT_W'(FLOAT_CYC)) hi_cnt <= hi_cnt + 1'b1;
         end else begin
            hi_cnt <= '0;
         end
      end
   end

   // R5: strobe only inside chip select
   p_oe_inside_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> !ce_n);

   // R4 / R5: done coincides with release of both enables
   p_done_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ce_n && oe_n && $past(!ce_n)));

   // R10: single-cycle done
   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4: chip select low for exactly the sample window
   p_low_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ce_n) |-> (lo_cnt == CNT_W'(SAMPLE_CYC)));

   // R7: float gap respected before every new select
   p_float_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ce_n) |-> (hi_cnt >= CNT_W'(FLOAT_CYC)));

endmodule

// File: rtl/pmem_rd_datapath.sv
`timescale 1ns/1ps
module pmem_rd_datapath #(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] mem_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] rd_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
         rd_data  <= '0;
      end else begin
         if (accept)  mem_addr <= req_addr;
         if (capture) rd_data  <= mem_data;
      end
   end

   // R10: captured byte held between captures
   p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(rd_data));

   // R6: address register moves only on acceptance
   p_addr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(mem_addr));

endmodule

// File: rtl/pmem_rd_ctrl.sv
`timescale 1ns/1ps
module pmem_rd_ctrl
   import pmem_rd_pkg::*;
#(
   parameter int unsigned ADDR_W        = 15,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned CLK_PERIOD_NS = 10,
   parameter int unsigned T_ACC_NS      = 120,
   parameter int unsigned T_OE_NS       = 60,
   parameter int unsigned T_FLOAT_NS    = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_start,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_done,
   output logic              rd_busy,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   input  logic [DATA_W-1:0] mem_data_in
);

   if (CLK_PERIOD_NS == 0) begin : g_bad_clk
      $error("clock period must be nonzero");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("bus widths must be nonzero");
   end

   localparam int unsigned ACC_CYC    = ns_to_cyc(T_ACC_NS, CLK_PERIOD_NS);
   localparam int unsigned OE_CYC     = ns_to_cyc(T_OE_NS, CLK_PERIOD_NS);
   localparam int unsigned FLOAT_CYC  = ns_to_cyc(T_FLOAT_NS, CLK_PERIOD_NS);
   localparam int unsigned SAMPLE_CYC = umax(ACC_CYC, OE_CYC);
   localparam int unsigned CNT_W      = $clog2(umax(SAMPLE_CYC, FLOAT_CYC) + 1);

   logic accept;
   logic capture;

   pmem_rd_sched #(
      .SAMPLE_CYC (SAMPLE_CYC),
      .OE_CYC     (OE_CYC),
      .FLOAT_CYC  (FLOAT_CYC),
      .CNT_W      (CNT_W)
   ) u_sched (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (rd_start),
      .accept  (accept),
      .capture (capture),
      .ce_n    (mem_ce_n),
      .oe_n    (mem_oe_n),
      .done    (rd_done),
      .busy    (rd_busy)
   );

   pmem_rd_datapath #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .capture  (capture),
      .req_addr (rd_addr),
      .mem_data (mem_data_in),
      .mem_addr (mem_addr),
      .rd_data  (rd_data)
   );

   // R6: pins steady for the whole select window
   p_addr_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

   // R8: request while busy does not reach the pins
   p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_start && rd_busy) |=> $stable(mem_addr));

   // R2: accepted request selects the memory next cycle
   p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_start && !rd_busy) |=> (!mem_ce_n && rd_busy));

endmodule

// File: tb/sim_pmem_rd_ctrl.sv
`timescale 1ns/1ps
module sim_mem_model #(
   parameter int ACC_C = 1,
   parameter int OE_C  = 1
) (
   input  logic        clk,
   input  logic [14:0] addr,
   input  logic        ce_n,
   input  logic        oe_n,
   output logic [7:0]  data
);
   int          acc;
   int          oec;
   logic [14:0] tag;

   function automatic logic [7:0] mem_fn(input logic [14:0] a);
      return a[7:0] ^ {a[14:8], 1'b1};
   endfunction

   initial begin
      acc = 0;
      oec = 0;
      tag = '0;
   end

   always @(posedge clk) begin
      if (ce_n)             acc <= 0;
      else if (addr == tag) acc <= acc + 1;
      else                  acc <= 1;
      tag <= addr;
      if (oe_n) oec <= 0;
      else      oec <= oec + 1;
   end

   always_comb begin
      if (!ce_n && !oe_n && acc >= ACC_C - 1 && oec >= OE_C - 1)
         data = mem_fn(addr);
      else
         data = ~mem_fn(addr);
   end
endmodule

module sim_pmem_rd_ctrl;
   localparam int CLK_NS = 8;

   logic clk;
   logic rst_n;
   logic [1:0]  start_v;
   logic [14:0] raddr_v [2];
   logic [7:0]  rdata_v [2];
   logic [14:0] maddr_v [2];
   logic [7:0]  mdata_v [2];
   logic [1:0]  done_v, busy_v, ce_n_v, oe_n_v;

   int n_chk;
   int n_err;
   int e_s [2];
   int e_d [2];
   int e_f [2];

   function automatic int cdiv(input int ns);
      int c;
      c = (ns + CLK_NS - 1) / CLK_NS;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic logic [7:0] mem_fn(input logic [14:0] a);
      return a[7:0] ^ {a[14:8], 1'b1};
   endfunction

   // u0: 150/70/50 ns grade; u1: strobe slower than access, zero float
   pmem_rd_ctrl #(.CLK_PERIOD_NS(CLK_NS), .T_ACC_NS(150), .T_OE_NS(70),
                  .T_FLOAT_NS(50)) u0 (
      .clk(clk), .rst_n(rst_n), .rd_start(start_v[0]), .rd_addr(raddr_v[0]),
      .rd_data(rdata_v[0]), .rd_done(done_v[0]), .rd_busy(busy_v[0]),
      .mem_addr(maddr_v[0]), .mem_ce_n(ce_n_v[0]), .mem_oe_n(oe_n_v[0]),
      .mem_data_in(mdata_v[0]));

   pmem_rd_ctrl #(.CLK_PERIOD_NS(CLK_NS), .T_ACC_NS(20), .T_OE_NS(30),
                  .T_FLOAT_NS(0)) u1 (
      .clk(clk), .rst_n(rst_n), .rd_start(start_v[1]), .rd_addr(raddr_v[1]),
      .rd_data(rdata_v[1]), .rd_done(done_v[1]), .rd_busy(busy_v[1]),
      .mem_addr(maddr_v[1]), .mem_ce_n(ce_n_v[1]), .mem_oe_n(oe_n_v[1]),
      .mem_data_in(mdata_v[1]));

   sim_mem_model #(.ACC_C(19), .OE_C(9)) u_m0 (.clk(clk), .addr(maddr_v[0]),
      .ce_n(ce_n_v[0]), .oe_n(oe_n_v[0]), .data(mdata_v[0]));
   sim_mem_model #(.ACC_C(3), .OE_C(4)) u_m1 (.clk(clk), .addr(maddr_v[1]),
      .ce_n(ce_n_v[1]), .oe_n(oe_n_v[1]), .data(mdata_v[1]));

   initial clk = 1'b0;
   always #(CLK_NS / 2) clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_ready(input int i);
      while (busy_v[i]) @(negedge clk);
   endtask

   // issue one read; returns cycle of done and of strobe fall after select
   task automatic do_read(input int i, input logic [14:0] a, input bit inject,
                          input logic [14:0] b, output int done_k, output int oe_k);
      wait_ready(i);
      start_v[i] = 1'b1;
      raddr_v[i] = a;
      @(negedge clk);
      start_v[i] = 1'b0;
      check(!ce_n_v[i], "R2 select", ce_n_v[i], 0);
      check(maddr_v[i] == a, "R2 address", maddr_v[i], a);
      done_k = -1;
      oe_k   = oe_n_v[i] ? -1 : 0;
      for (int k = 1; k <= 200; k++) begin
         if (inject && k == 2) begin start_v[i] = 1'b1; raddr_v[i] = b; end
         if (inject && k == 3) start_v[i] = 1'b0;
         @(negedge clk);
         if (oe_k < 0 && !oe_n_v[i]) oe_k = k;
         if (!ce_n_v[i] && maddr_v[i] != a)
            check(0, "R6 address moved", maddr_v[i], a);
         if (done_v[i]) begin done_k = k; break; end
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      start_v = '0;
      raddr_v[0] = '0;
      raddr_v[1] = '0;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 2; i++) begin
         check(ce_n_v[i] && oe_n_v[i], "R1 enables in reset", {ce_n_v[i], oe_n_v[i]}, 3);
         check(!done_v[i] && !busy_v[i], "R1 done/busy in reset", {done_v[i], busy_v[i]}, 0);
         check(rdata_v[i] == 8'h00, "R1 data in reset", rdata_v[i], 0);
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(ce_n_v[0] && !busy_v[0] && !done_v[0], "R1 idle after reset",
            {ce_n_v[0], busy_v[0], done_v[0]}, 4);
   endtask

   task automatic t_basic(input int i, input logic [14:0] a);
      int dk, ok;
      do_read(i, a, 1'b0, '0, dk, ok);
      check(dk == e_s[i], "R4 capture cycle", dk, e_s[i]);
      check(ok == e_d[i], "R3 strobe lead", ok, e_d[i]);
      check(rdata_v[i] == mem_fn(a), "R4 captured byte", rdata_v[i], mem_fn(a));
      check(ce_n_v[i] && oe_n_v[i], "R5 release with done", {ce_n_v[i], oe_n_v[i]}, 3);
      check(busy_v[i] == (e_f[i] > 1), "R8 busy during float", busy_v[i], e_f[i] > 1);
      @(negedge clk);
      check(!done_v[i], "R10 done single cycle", done_v[i], 0);
   endtask

   task automatic t_conv();
      int dk, ok;
      do_read(0, 15'h1234, 1'b0, '0, dk, ok);
      check(dk == 19, "R9 ceil 150ns/8ns", dk, 19);
      check(ok == 10, "R9 ceil lead 19-9", ok, 10);
      do_read(1, 15'h0F0F, 1'b0, '0, dk, ok);
      check(dk == 4 && ok == 0, "R9 strobe-bound window", dk, 4);
   endtask

   task automatic t_ignore();
      int dk, ok;
      do_read(0, 15'h2AAA, 1'b1, 15'h5555, dk, ok);
      check(dk == e_s[0], "R8 timing unchanged", dk, e_s[0]);
      check(rdata_v[0] == mem_fn(15'h2AAA), "R8 data of first request",
            rdata_v[0], mem_fn(15'h2AAA));
      repeat (e_f[0] + 4) begin
         @(negedge clk);
         if (!ce_n_v[0]) check(0, "R8 phantom access", 0, 1);
      end
      check(maddr_v[0] == 15'h2AAA, "R8 address untouched", maddr_v[0], 15'h2AAA);
   endtask

   task automatic t_gap(input int i, input logic [14:0] a1, input logic [14:0] a2);
      int hi;
      wait_ready(i);
      start_v[i] = 1'b1;
      raddr_v[i] = a1;
      @(negedge clk);
      raddr_v[i] = a2;
      while (!done_v[i]) @(negedge clk);
      check(rdata_v[i] == mem_fn(a1), "R4 first of pair", rdata_v[i], mem_fn(a1));
      hi = 0;
      for (int k = 0; k < 100; k++) begin
         if (!ce_n_v[i]) break;
         hi++;
         @(negedge clk);
      end
      start_v[i] = 1'b0;
      check(hi == e_f[i], "R7 float gap", hi, e_f[i]);
      check(maddr_v[i] == a2, "R2 second address", maddr_v[i], a2);
      while (!done_v[i]) @(negedge clk);
      check(rdata_v[i] == mem_fn(a2), "R4 second of pair", rdata_v[i], mem_fn(a2));
   endtask

   task automatic t_hold(input int i);
      logic [7:0] v;
      v = rdata_v[i];
      repeat (6) @(negedge clk);
      check(rdata_v[i] == v, "R10 data held", rdata_v[i], v);
      check(!done_v[i], "R10 no stray done", done_v[i], 0);
   endtask

   initial begin
      #(CLK_NS * 100000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      n_chk = 0;
      n_err = 0;
      e_s[0] = (cdiv(150) > cdiv(70)) ? cdiv(150) : cdiv(70);
      e_d[0] = e_s[0] - cdiv(70);
      e_f[0] = cdiv(50);
      e_s[1] = (cdiv(20) > cdiv(30)) ? cdiv(20) : cdiv(30);
      e_d[1] = e_s[1] - cdiv(30);
      e_f[1] = cdiv(0);
      @(negedge clk);
      t_reset();
      t_basic(0, 15'h7FFF);
      t_basic(0, 15'h0000);
      t_basic(1, 15'h4321);
      t_conv();
      t_ignore();
      t_gap(0, 15'h0101, 15'h7E7E);
      t_gap(1, 15'h1111, 15'h2222);
      t_hold(0);
      t_hold(1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule